// File: doc/BRIEF.md
# Audio Auto-Mute Detector

This block sits beside a two-channel serial audio path and decides when each channel's output stage should be silenced. It watches the left and right sample streams as they are accepted on a shared valid strobe. When both channels have carried a long unbroken run of static data, it raises a shared automatic mute. A static run is made of words that are entirely zeros or entirely ones, all equal to each other. As soon as either channel carries anything else, the automatic mute is withdrawn. Separate manual mute inputs silence their own channel at once, whatever the automatic logic is doing.

Each channel has its own run tracker. The tracker counts consecutive accepted static words and stops counting at the threshold. A small controller turns the two trackers' "run complete" flags and the active-low enable into the shared automatic request. The controller has three states. `AM_OFF` means automatic muting is disabled. `AM_WATCH` means it is enabled but not muting. `AM_MUTED` means it is enabled and muting. The transitions are:
- any state to `AM_OFF` when the enable is high;
- `AM_OFF` to `AM_MUTED` when the enable is low and both runs are complete;
- `AM_OFF` to `AM_WATCH` when the enable is low and the runs are not both complete;
- `AM_WATCH` to `AM_MUTED` when both runs are complete;
- `AM_MUTED` to `AM_WATCH` when either run is broken.

A mixer ORs the request into each channel's manual mute.

Top module: `amute_detector`

## Requirements
- R1: While reset is low, and after it is released, the automatic mute is off, so each mute output equals its manual mute input. Reset also clears both run counts, so a single static word after reset does not mute.
- R2: The mute outputs go high one clock edge after the edge that accepts the RUN_LEN-th (default 8192) consecutive identical static word on the later of the two channels. Only RUN_LEN-1 such words leave them low.
- R3: Automatic mute needs complete runs on both channels. A channel whose words keep changing holds it off, even if the other channel is static indefinitely.
- R4: The two channels may be static at different levels, for example left all-zeros and right all-ones, and still trigger the automatic mute.
- R5: An accepted word on either channel that differs from that channel's previous word restarts that channel's run at one. The automatic mute then drops one edge after the edge that accepted the word.
- R6: A word with mixed bits (neither all-zeros nor all-ones, e.g. 4'b0101) never counts as static. Repeating such a word never triggers the automatic mute.
- R7: Cycles with samp_valid low are ignored. The data lines in those cycles neither advance nor break a run.
- R8: A run longer than RUN_LEN keeps the mute asserted. Each run count saturates at RUN_LEN and never wraps.
- R9: With auto_mute_n high, the automatic mute is off one edge later, but the run counters keep tracking. Driving auto_mute_n low while both runs are complete mutes again one edge later.
- R10: man_mute_l and man_mute_r drive their own channel's mute output combinationally in the same cycle. Each affects only its own channel, and the automatic state has no effect on them.
- R11: Each mute output is high when its manual mute or the automatic mute is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Accept the current left and right words |
| left_sample | input | SAMPLE_W | Left channel word |
| right_sample | input | SAMPLE_W | Right channel word |
| auto_mute_n | input | 1 | Active-low enable for automatic muting |
| man_mute_l | input | 1 | Manual mute for the left channel |
| man_mute_r | input | 1 | Manual mute for the right channel |
| mute_l | output | 1 | Left channel mute control |
| mute_r | output | 1 | Right channel mute control |

## Verification
The bench aims at the threshold boundary: after RUN_LEN-1 words the outputs must be low, and after the RUN_LEN-th word they must be high only from the following edge. An off-by-one counter would fire early or late. It runs one channel well past twice the threshold, which exposes a counter that wraps instead of saturating and drops the mute in a long silence. It interleaves invalid cycles carrying mixed-bit garbage and repeats a mixed-bit word, which catches trackers that look at unqualified data or that count equality without a flatness test. It also toggles one channel against a static partner and disables then re-enables the feature mid-run, which reveals an OR where an AND belongs and counters wrongly frozen while disabled.

// File: rtl/amute_pkg.sv
package amute_pkg;

    // Controller states for the shared automatic mute request
    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,   // feature disabled by auto_mute_n
        AM_WATCH = 2'd1,   // enabled, waiting for both runs to complete
        AM_MUTED = 2'd2    // enabled, both runs complete, mute requested
    } am_state_e;

    localparam int unsigned AM_NUM_CH = 2;

endpackage

// File: rtl/amute_run_tracker.sv
module amute_run_tracker #(
    parameter int unsigned SAMPLE_W = 1,
    parameter int unsigned RUN_LEN  = 8192,
    parameter int unsigned CNT_W    = $clog2(RUN_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [CNT_W-1:0]    run_cnt,
    output logic                run_full
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [SAMPLE_W-1:0] last_q, last_d;
    logic [CNT_W-1:0]    cnt_q, cnt_d;
    logic                is_flat;
    logic                same_word;

    // A word is static only when every bit agrees
    assign is_flat   = (sample == '0) || (sample == '1);
    // A non-zero count implies last_q holds a previously accepted word
    assign same_word = (cnt_q != '0) && (sample == last_q);

    always_comb begin
        cnt_d  = cnt_q;
        last_d = last_q;
        if (valid) begin
            last_d = sample;
            if (!is_flat) begin
                cnt_d = '0;
            end else if (same_word) begin
                cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
            end else begin
                cnt_d = CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            last_q <= last_d;
        end
    end

    assign run_cnt  = cnt_q;
    assign run_full = (cnt_q == CNT_MAX);

endmodule

// File: rtl/amute_ctrl.sv
module amute_ctrl
    import amute_pkg::*;
#(
    parameter int unsigned NCH = AM_NUM_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable_n,
    input  logic [NCH-1:0] chan_full,
    output logic           auto_req
);

    am_state_e state_q, state_d;
    logic      all_full;

    assign all_full = &chan_full;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (enable_n) begin
            state_d = AM_OFF;
        end else begin
            unique case (state_q)
                AM_OFF:   state_d = all_full ? AM_MUTED : AM_WATCH;
                AM_WATCH: state_d = all_full ? AM_MUTED : AM_WATCH;
                AM_MUTED: state_d = all_full ? AM_MUTED : AM_WATCH;
                default:  state_d = AM_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AM_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            AM_MUTED: auto_req = 1'b1;
            AM_OFF:   auto_req = 1'b0;
            AM_WATCH: auto_req = 1'b0;
            default:  auto_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/amute_mix.sv
module amute_mix #(
    parameter int unsigned NCH = 2
) (
    input  logic [NCH-1:0] man_mute,
    input  logic           auto_req,
    output logic [NCH-1:0] mute
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign mute[g] = man_mute[g] | auto_req;
    end

endmodule

// File: rtl/amute_detector.sv
module amute_detector
    import amute_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 1,
    parameter int unsigned RUN_LEN  = 8192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                samp_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                auto_mute_n,
    input  logic                man_mute_l,
    input  logic                man_mute_r,
    output logic                mute_l,
    output logic                mute_r
);

    localparam int unsigned NCH   = AM_NUM_CH;
    localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);

    logic [SAMPLE_W-1:0] samp_arr [NCH];
    logic [CNT_W-1:0]    run_cnt  [NCH];
    logic [NCH-1:0]      chan_full;
    logic [NCH-1:0]      man_vec;
    logic [NCH-1:0]      mute_vec;
    logic                auto_req;

    // Channel 0 is left, channel 1 is right
    assign samp_arr[0] = left_sample;
    assign samp_arr[1] = right_sample;
    assign man_vec     = {man_mute_r, man_mute_l};

    for (genvar c = 0; c < NCH; c++) begin : g_trk
        amute_run_tracker #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN),
            .CNT_W    (CNT_W)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid    (samp_valid),
            .sample   (samp_arr[c]),
            .run_cnt  (run_cnt[c]),
            .run_full (chan_full[c])
        );
    end

    amute_ctrl #(
        .NCH       (NCH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable_n  (auto_mute_n),
        .chan_full (chan_full),
        .auto_req  (auto_req)
    );

    amute_mix #(
        .NCH      (NCH)
    ) u_mix (
        .man_mute (man_vec),
        .auto_req (auto_req),
        .mute     (mute_vec)
    );

    assign mute_l = mute_vec[0];
    assign mute_r = mute_vec[1];

endmodule

// File: rtl/amute_checker.sv
module amute_checker #(
    parameter int unsigned SAMPLE_W = 1,
    parameter int unsigned RUN_LEN  = 8192,
    parameter int unsigned CNT_W    = $clog2(RUN_LEN + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                samp_valid,
    input logic [SAMPLE_W-1:0] left_sample,
    input logic                auto_mute_n,
    input logic                man_mute_l,
    input logic                man_mute_r,
    input logic                mute_l,
    input logic                mute_r,
    input logic                auto_req,
    input logic [1:0]          chan_full,
    input logic [CNT_W-1:0]    cnt_l,
    input logic [CNT_W-1:0]    cnt_r
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    AST_MANUAL_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        man_mute_l |-> mute_l);                                            // R10
    AST_MANUAL_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        man_mute_r |-> mute_r);                                            // R10
    AST_ENGAGE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(auto_req) |-> $past(&chan_full));                            // R3
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        auto_mute_n |=> !auto_req);                                        // R9
    AST_MIXED_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !((left_sample == '0) || (left_sample == '1))) |=> ##1 !auto_req); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_l <= CNT_MAX) && (cnt_r <= CNT_MAX));                         // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> ($stable(cnt_l) && $stable(cnt_r)));               // R7

endmodule

bind amute_detector amute_checker #(
    .SAMPLE_W (SAMPLE_W),
    .RUN_LEN  (RUN_LEN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_valid  (samp_valid),
    .left_sample (left_sample),
    .auto_mute_n (auto_mute_n),
    .man_mute_l  (man_mute_l),
    .man_mute_r  (man_mute_r),
    .mute_l      (mute_l),
    .mute_r      (mute_r),
    .auto_req    (auto_req),
    .chan_full   (chan_full),
    .cnt_l       (run_cnt[0]),
    .cnt_r       (run_cnt[1])
);

// File: tb/tb_amute_detector.sv
module tb_amute_detector;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 4;
    localparam int RUN        = 8192;
    localparam int WATCHDOG   = 180000;
    localparam logic [SW-1:0] ZW = 4'h0;
    localparam logic [SW-1:0] OW = 4'hF;

    // {phase, man_l, man_r, exp_l, exp_r}; phase 1 entries run with auto-mute engaged
    localparam logic [4:0] VTAB [8] = '{
        5'b0_00_00, 5'b0_01_01, 5'b0_10_10, 5'b0_11_11,
        5'b1_00_11, 5'b1_01_11, 5'b1_10_11, 5'b1_11_11
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          samp_valid = 1'b0;
    logic [SW-1:0] left_s = '0;
    logic [SW-1:0] right_s = '0;
    logic          auto_mute_n = 1'b0;
    logic          man_l = 1'b0;
    logic          man_r = 1'b0;
    logic          mute_l;
    logic          mute_r;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amute_detector #(
        .SAMPLE_W (SW),
        .RUN_LEN  (RUN)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .samp_valid   (samp_valid),
        .left_sample  (left_s),
        .right_sample (right_s),
        .auto_mute_n  (auto_mute_n),
        .man_mute_l   (man_l),
        .man_mute_r   (man_r),
        .mute_l       (mute_l),
        .mute_r       (mute_r)
    );

    task automatic check(input string tag, input logic [1:0] exp);
        logic [1:0] got;
        got = {mute_l, mute_r};
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {mute_l,mute_r} actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        samp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive n accepted words back to back; returns at the negedge after the last accepting edge
    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r, input int n, input bit alt_r);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            samp_valid = 1'b1;
            left_s  = l;
            right_s = (alt_r && k[0]) ? ~r : r;
        end
        @(negedge clk);
        samp_valid = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual still running, expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1 during reset", 2'b00);
        do_reset();
        settle();
        check("R1 after reset", 2'b00);

        // R10 / R11: table of manual mute combinations, without then with auto-mute
        for (int i = 0; i < 8; i++) begin
            if (i == 4) begin
                man_l = 1'b0;
                man_r = 1'b0;
                push(ZW, ZW, RUN, 1'b0);
                settle();
            end
            @(negedge clk);
            man_l = VTAB[i][3];
            man_r = VTAB[i][2];
            #1;
            check(VTAB[i][4] ? "R11 manual with auto" : "R10 manual only", VTAB[i][1:0]);
        end
        man_l = 1'b0;
        man_r = 1'b0;

        // R1: reset from a muted state clears the runs
        do_reset();
        settle();
        check("R1 reset clears mute", 2'b00);
        push(ZW, ZW, 1, 1'b0);
        settle();
        check("R1 counts cleared", 2'b00);

        // R2: threshold boundary (one word already counted above)
        push(ZW, ZW, RUN - 2, 1'b0);
        settle();
        check("R2 at RUN_LEN-1", 2'b00);
        push(ZW, ZW, 1, 1'b0);
        check("R2 before extra edge", 2'b00);
        settle();
        check("R2 at RUN_LEN", 2'b11);

        // R8: run far past twice the threshold
        push(ZW, ZW, 9000, 1'b0);
        settle();
        check("R8 saturation", 2'b11);

        // R5: left changes level
        push(OW, ZW, 1, 1'b0);
        check("R5 left change, same cycle", 2'b11);
        settle();
        check("R5 left change released", 2'b00);

        // R4: left all-ones, right all-zeros re-engages
        push(OW, ZW, RUN - 1, 1'b0);
        settle();
        check("R4 mixed levels", 2'b11);

        // R5: right changes level
        push(OW, OW, 1, 1'b0);
        settle();
        check("R5 right change released", 2'b00);

        // R3: right keeps toggling while left static
        do_reset();
        push(ZW, ZW, 9000, 1'b1);
        settle();
        check("R3 one channel busy", 2'b00);

        // R6: mixed-bit word repeated
        do_reset();
        push(4'b0101, 4'b0101, 9000, 1'b0);
        settle();
        check("R6 mixed word", 2'b00);

        // R7: idle cycles carry garbage between accepted static words
        do_reset();
        for (int k = 0; k < RUN; k++) begin
            @(negedge clk);
            samp_valid = 1'b1;
            left_s  = ZW;
            right_s = ZW;
            @(negedge clk);
            samp_valid = 1'b0;
            left_s  = 4'b0110;
            right_s = 4'b1001;
        end
        settle();
        check("R7 idle ignored", 2'b11);

        // R9: disable, keep counting, re-enable
        @(negedge clk);
        auto_mute_n = 1'b1;
        @(negedge clk);
        check("R9 disabled", 2'b00);
        push(ZW, ZW, 100, 1'b0);
        settle();
        check("R9 still disabled", 2'b00);
        auto_mute_n = 1'b0;
        @(negedge clk);
        check("R9 re-enabled", 2'b11);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule